// File: doc/BRIEF.md
# Indexed Register File Port

A 32-bit control window for a display controller, reached through only a few I/O word addresses. A host first writes a register number to the index address. Each following read or write at the value address then goes to the register that number selects. The selected number persists, so a host can read the same register many times without writing the index again. A third address is a placeholder: its reads return zero and its writes have no effect.

Behind the window sit several groups of registers. There is a version word that accepts only three legal codes. Width and height are range-checked against fixed maxima. Some registers are read-only and derived: rounded colour depth, line pitch and a capability mask. There are two controls: a display enable, and a configuration commit. The commit validates the four command-ring pointers supplied by the ring memory before the ring is marked usable. Cursor state has its own registers. A synchronise request starts the command parser and raises a busy flag. A small block of general-purpose scratch words completes the set.

When the `LEGACY_LAYOUT` parameter is set, the address spacing changes from one word to four. Every request gets exactly one response, one cycle later.

Top module: `idxreg_port`

## Requirements
- R1: Word offset 0 (times 4 when `LEGACY_LAYOUT`=1) is the index address, and reads of it return the stored index. Offset 1 (scaled) is the value address. Offset 2 (scaled) reads as 0, and writes to it change nothing. Any other offset reads as 0xFFFFFFFF. Every request gets `rsp_valid_o` high on the next cycle, with the read data in the same cycle.
- R2: Register 0 is the version word. It resets to 0x90000002. A write to it is taken only if the value is 0x90000000, 0x90000001 or 0x90000002; any other value leaves it unchanged.
- R3: Register 2 is width and register 3 is height. A write is taken only if the value is at most 2360 (width) or at most 1770 (height). Registers 4 and 5 read 2360 and 1770. The reset values are 1024 and 768, and both values drive output ports.
- R4: Register 7 reads (DEPTH+7) rounded down to a multiple of 8, which is 16 with the default depth of 15. Writes to it have no effect.
- R5: Register 12 reads BYTES_PP (default 2) multiplied by the current width.
- R6: Register 17 reads a capability mask: bits 0 and 1 are always set, and bits 5, 6 and 7 are set only when `CURSOR_EN`=1. The default reads 0x000000E3.
- R7: Register 1 holds the enable bit, taken from bit 0 of the written value. It reads back and drives `fb_enable_o`, which is 0 after reset.
- R8: A write to register 20 sets the configured flag only if the value is non-zero and all four ring pointers are 4-byte aligned, with max ≤ 0x10000 and max ≥ min + 10240. Otherwise the write clears the flag. The flag reads back and drives `ring_ok_o`, and it is 0 after reset.
- R9: A write to register 21 raises `parse_start_o` for exactly one cycle and sets busy. Busy reads at register 22 and drives `busy_o`. It clears on the first later cycle in which `parser_idle_i` is 1.
- R10: Registers 24, 25 and 26 are read/write words for cursor id, X and Y. For register 27, writing 1 sets the cursor-on flag, writing 0 clears it, and any other value leaves it unchanged.
- R11: Indices 1792 to 1792+SCRATCH_SIZE−1 (default 8 words) are read/write scratch storage that resets to 0. The indices just outside this range behave as unknown indices.
- R12: An index that maps to no register reads as 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word offset inside the I/O window |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata_o | output | 32 | Read data (0 for writes) |
| ring_min_i | input | 32 | Ring start pointer in bytes |
| ring_max_i | input | 32 | Ring end pointer in bytes |
| ring_next_i | input | 32 | Ring producer pointer |
| ring_stop_i | input | 32 | Ring consumer pointer |
| parser_idle_i | input | 1 | Command parser reports idle |
| fb_enable_o | output | 1 | Display enable |
| ring_ok_o | output | 1 | Ring configured and validated |
| width_o | output | DIM_W | Pending width |
| height_o | output | DIM_W | Pending height |
| cursor_on_o | output | 1 | Cursor visible |
| cursor_x_o | output | 32 | Cursor X |
| cursor_y_o | output | 32 | Cursor Y |
| parse_start_o | output | 1 | One-cycle parser start pulse |
| busy_o | output | 1 | Synchronise in progress |

## Verification
A register write takes effect at the clock edge that samples the request. The read response, and every output it changes (`fb_enable_o`, `ring_ok_o`, `parse_start_o`, `busy_o`, cursor and mode ports), is visible from the next edge onward. The bench therefore samples these outputs at the falling edge that follows the write. A read result arrives one edge after its request. Each driven request pushes its expected word into a queue, and a monitor on the falling edge pops one entry for every `rsp_valid_o`. Busy clearing is checked only after `parser_idle_i` has been high across a full edge.

// File: rtl/idxreg_pkg.sv
package idxreg_pkg;
  typedef logic [31:0] word_t;

  localparam word_t REG_VERSION = 32'd0;
  localparam word_t REG_ENABLE  = 32'd1;
  localparam word_t REG_WIDTH   = 32'd2;
  localparam word_t REG_HEIGHT  = 32'd3;
  localparam word_t REG_WMAX    = 32'd4;
  localparam word_t REG_HMAX    = 32'd5;
  localparam word_t REG_BPP     = 32'd7;
  localparam word_t REG_PITCH   = 32'd12;
  localparam word_t REG_CAPS    = 32'd17;
  localparam word_t REG_COMMIT  = 32'd20;
  localparam word_t REG_SYNC    = 32'd21;
  localparam word_t REG_BUSY    = 32'd22;
  localparam word_t REG_CUR_ID  = 32'd24;
  localparam word_t REG_CUR_X   = 32'd25;
  localparam word_t REG_CUR_Y   = 32'd26;
  localparam word_t REG_CUR_ON  = 32'd27;
  localparam word_t SCRATCH_BASE = 32'd1792;

  localparam word_t VERSION_V0 = 32'h9000_0000;
  localparam word_t VERSION_V1 = 32'h9000_0001;
  localparam word_t VERSION_V2 = 32'h9000_0002;

  localparam word_t WIDTH_LIMIT  = 32'd2360;
  localparam word_t HEIGHT_LIMIT = 32'd1770;

  localparam word_t CUR_HIDE = 32'd0;
  localparam word_t CUR_SHOW = 32'd1;
endpackage

// File: rtl/idxreg_decode.sv
module idxreg_decode #(
  parameter int ADDR_W = 4,
  parameter int STRIDE = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sel_index_o,
  output logic              sel_value_o,
  output logic              sel_stub_o
);
  localparam logic [ADDR_W-1:0] OFS_INDEX = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_VALUE = ADDR_W'(STRIDE);
  localparam logic [ADDR_W-1:0] OFS_STUB  = ADDR_W'(2 * STRIDE);

  always_comb begin
    sel_index_o = (addr_i == OFS_INDEX);
    sel_value_o = (addr_i == OFS_VALUE);
    sel_stub_o  = (addr_i == OFS_STUB);
  end
endmodule

// File: rtl/idxreg_ring_check.sv
module idxreg_ring_check #(
  parameter int unsigned RING_LIMIT = 32'h0001_0000,
  parameter int unsigned MIN_SPAN   = 10240
) (
  input  logic [31:0] min_i,
  input  logic [31:0] max_i,
  input  logic [31:0] next_i,
  input  logic [31:0] stop_i,
  output logic        ok_o
);
  logic [1:0]  low_bits;
  logic [32:0] need_max;
  logic        aligned, under_limit, wide_enough;

  always_comb begin
    low_bits    = min_i[1:0] | max_i[1:0] | next_i[1:0] | stop_i[1:0];
    aligned     = (low_bits == 2'b00);
    under_limit = (max_i <= RING_LIMIT);
    need_max    = {1'b0, min_i} + 33'(MIN_SPAN);
    wide_enough = ({1'b0, max_i} >= need_max);
    ok_o        = aligned && under_limit && wide_enough;
  end
endmodule

// File: rtl/idxreg_scratch.sv
module idxreg_scratch #(
  parameter int WORDS = 8,
  parameter int AW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic hit;
    always_comb hit = we_i && (waddr_i == AW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mem_q[g] <= '0;
      else if (hit) mem_q[g] <= wdata_i;
    end
  end

  always_comb rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/idxreg_port.sv
module idxreg_port
  import idxreg_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter bit LEGACY_LAYOUT = 1'b0,
  parameter int DIM_W         = 12,
  parameter int DEPTH         = 15,
  parameter int BYTES_PP      = 2,
  parameter bit CURSOR_EN     = 1'b1,
  parameter int SCRATCH_SIZE  = 8,
  parameter int RESET_W       = 1024,
  parameter int RESET_H       = 768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  input  logic [31:0]       ring_min_i,
  input  logic [31:0]       ring_max_i,
  input  logic [31:0]       ring_next_i,
  input  logic [31:0]       ring_stop_i,
  input  logic              parser_idle_i,
  output logic              fb_enable_o,
  output logic              ring_ok_o,
  output logic [DIM_W-1:0]  width_o,
  output logic [DIM_W-1:0]  height_o,
  output logic              cursor_on_o,
  output logic [31:0]       cursor_x_o,
  output logic [31:0]       cursor_y_o,
  output logic              parse_start_o,
  output logic              busy_o
);
  localparam int    STRIDE   = LEGACY_LAYOUT ? 4 : 1;
  localparam int    SCR_AW   = (SCRATCH_SIZE > 1) ? $clog2(SCRATCH_SIZE) : 1;
  localparam word_t BPP_READ = word_t'((DEPTH + 7) & ~7);
  localparam word_t CAP_MASK = 32'h0000_0003 | (CURSOR_EN ? 32'h0000_00E0 : 32'h0);
  localparam word_t SCR_END  = SCRATCH_BASE + word_t'(SCRATCH_SIZE);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // address decode
  logic sel_index, sel_value, sel_stub;
  idxreg_decode #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_decode (
    .addr_i      (req_addr_i),
    .sel_index_o (sel_index),
    .sel_value_o (sel_value),
    .sel_stub_o  (sel_stub)
  );

  // ring pointer validation
  logic ring_valid;
  idxreg_ring_check u_ring (
    .min_i  (ring_min_i),
    .max_i  (ring_max_i),
    .next_i (ring_next_i),
    .stop_i (ring_stop_i),
    .ok_o   (ring_valid)
  );

  // state
  word_t            index_q, index_n;
  word_t            version_q, version_n;
  logic             enable_q, enable_n;
  logic [DIM_W-1:0] width_q, width_n, height_q, height_n;
  logic             ring_ok_q, ring_ok_n;
  logic             busy_q, busy_n;
  logic             start_q, start_n;
  word_t            cur_id_q, cur_id_n, cur_x_q, cur_x_n, cur_y_q, cur_y_n;
  logic             cur_on_q, cur_on_n;
  logic             rsp_valid_q;
  word_t            rsp_data_q, rsp_data_n;

  // write strobes
  logic wr_req, idx_wr, val_wr, cfg_wr, sync_wr, curon_wr;
  logic scr_hit, scr_wr;
  logic [SCR_AW-1:0] scr_addr;
  word_t scr_rdata;

  always_comb begin
    wr_req   = req_valid_i && req_write_i;
    idx_wr   = wr_req && sel_index;
    val_wr   = wr_req && sel_value;
    cfg_wr   = val_wr && (index_q == REG_COMMIT);
    sync_wr  = val_wr && (index_q == REG_SYNC);
    curon_wr = val_wr && (index_q == REG_CUR_ON);
    scr_hit  = (index_q >= SCRATCH_BASE) && (index_q < SCR_END);
    scr_wr   = val_wr && scr_hit;
    scr_addr = SCR_AW'(index_q - SCRATCH_BASE);
  end

  idxreg_scratch #(.WORDS(SCRATCH_SIZE), .AW(SCR_AW)) u_scratch (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .we_i    (scr_wr),
    .waddr_i (scr_addr),
    .wdata_i (req_wdata_i),
    .raddr_i (scr_addr),
    .rdata_o (scr_rdata)
  );

  // next-state logic
  always_comb begin
    index_n   = idx_wr ? req_wdata_i : index_q;
    version_n = version_q;
    enable_n  = enable_q;
    width_n   = width_q;
    height_n  = height_q;
    cur_id_n  = cur_id_q;
    cur_x_n   = cur_x_q;
    cur_y_n   = cur_y_q;
    cur_on_n  = cur_on_q;
    ring_ok_n = ring_ok_q;
    if (val_wr) begin
      case (index_q)
        REG_VERSION:
          if (req_wdata_i == VERSION_V0 || req_wdata_i == VERSION_V1 ||
              req_wdata_i == VERSION_V2) version_n = req_wdata_i;
        REG_ENABLE: enable_n = req_wdata_i[0];
        REG_WIDTH:
          if (req_wdata_i <= WIDTH_LIMIT) width_n = req_wdata_i[DIM_W-1:0];
        REG_HEIGHT:
          if (req_wdata_i <= HEIGHT_LIMIT) height_n = req_wdata_i[DIM_W-1:0];
        REG_CUR_ID: cur_id_n = req_wdata_i;
        REG_CUR_X:  cur_x_n  = req_wdata_i;
        REG_CUR_Y:  cur_y_n  = req_wdata_i;
        default: ;
      endcase
    end
    if (curon_wr) begin
      if (req_wdata_i == CUR_SHOW)      cur_on_n = 1'b1;
      else if (req_wdata_i == CUR_HIDE) cur_on_n = 1'b0;
    end
    if (cfg_wr) ring_ok_n = (req_wdata_i != '0) && ring_valid;
    start_n = sync_wr;
    if (sync_wr)            busy_n = 1'b1;
    else if (parser_idle_i) busy_n = 1'b0;
    else                    busy_n = busy_q;
  end

  // read data
  word_t reg_rd;
  always_comb begin
    reg_rd = '0;
    if (scr_hit) reg_rd = scr_rdata;
    else begin
      case (index_q)
        REG_VERSION: reg_rd = version_q;
        REG_ENABLE:  reg_rd = word_t'(enable_q);
        REG_WIDTH:   reg_rd = word_t'(width_q);
        REG_HEIGHT:  reg_rd = word_t'(height_q);
        REG_WMAX:    reg_rd = WIDTH_LIMIT;
        REG_HMAX:    reg_rd = HEIGHT_LIMIT;
        REG_BPP:     reg_rd = BPP_READ;
        REG_PITCH:   reg_rd = word_t'(width_q) * word_t'(BYTES_PP);
        REG_CAPS:    reg_rd = CAP_MASK;
        REG_COMMIT:  reg_rd = word_t'(ring_ok_q);
        REG_BUSY:    reg_rd = word_t'(busy_q);
        REG_CUR_ID:  reg_rd = cur_id_q;
        REG_CUR_X:   reg_rd = cur_x_q;
        REG_CUR_Y:   reg_rd = cur_y_q;
        REG_CUR_ON:  reg_rd = word_t'(cur_on_q);
        default:     reg_rd = '0;
      endcase
    end
    if (req_write_i)    rsp_data_n = '0;
    else if (sel_index) rsp_data_n = index_q;
    else if (sel_value) rsp_data_n = reg_rd;
    else if (sel_stub)  rsp_data_n = '0;
    else                rsp_data_n = '1;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      index_q     <= '0;
      version_q   <= VERSION_V2;
      enable_q    <= 1'b0;
      width_q     <= DIM_W'(RESET_W);
      height_q    <= DIM_W'(RESET_H);
      ring_ok_q   <= 1'b0;
      busy_q      <= 1'b0;
      start_q     <= 1'b0;
      cur_id_q    <= '0;
      cur_x_q     <= '0;
      cur_y_q     <= '0;
      cur_on_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      index_q     <= index_n;
      version_q   <= version_n;
      enable_q    <= enable_n;
      width_q     <= width_n;
      height_q    <= height_n;
      ring_ok_q   <= ring_ok_n;
      busy_q      <= busy_n;
      start_q     <= start_n;
      cur_id_q    <= cur_id_n;
      cur_x_q     <= cur_x_n;
      cur_y_q     <= cur_y_n;
      cur_on_q    <= cur_on_n;
      rsp_valid_q <= req_valid_i;
      if (req_valid_i) rsp_data_q <= rsp_data_n;
    end
  end

  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_rdata_o   = rsp_data_q;
  assign fb_enable_o   = enable_q;
  assign ring_ok_o     = ring_ok_q;
  assign width_o       = width_q;
  assign height_o      = height_q;
  assign cursor_on_o   = cur_on_q;
  assign cursor_x_o    = cur_x_q;
  assign cursor_y_o    = cur_y_q;
  assign parse_start_o = start_q;
  assign busy_o        = busy_q;

  // assertions
  p_rsp_next_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o);
  p_version_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (version_q == VERSION_V0) || (version_q == VERSION_V1) || (version_q == VERSION_V2));
  p_dim_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (word_t'(width_o) <= WIDTH_LIMIT) && (word_t'(height_o) <= HEIGHT_LIMIT));
  p_ring_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(ring_ok_o) |-> $past(cfg_wr));
  p_start_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    parse_start_o |-> busy_o);
  p_start_single_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    parse_start_o |=> !parse_start_o || $past(sync_wr));
  p_cursor_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (curon_wr && req_wdata_i != CUR_SHOW && req_wdata_i != CUR_HIDE) |=> $stable(cursor_on_o));
endmodule

// File: tb/idxreg_port_tb_top.sv
module idxreg_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [3:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] rmin, rmax, rnext, rstop;
  logic        p_idle;
  logic        fb_en, ring_ok, cur_on, p_start, busy;
  logic [11:0] w_o, h_o;
  logic [31:0] cx, cy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          is_rd;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  idxreg_port dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .ring_min_i(rmin), .ring_max_i(rmax), .ring_next_i(rnext), .ring_stop_i(rstop),
    .parser_idle_i(p_idle), .fb_enable_o(fb_en), .ring_ok_o(ring_ok),
    .width_o(w_o), .height_o(h_o), .cursor_on_o(cur_on),
    .cursor_x_o(cx), .cursor_y_o(cy), .parse_start_o(p_start), .busy_o(busy)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [3:0] a, logic [31:0] d, logic [31:0] exp, string tag);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    it.is_rd = !wr; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr_reg(int n, logic [31:0] d);
    access(1'b1, 4'd0, 32'(n), 32'h0, "idx");
    access(1'b1, 4'd1, d, 32'h0, "val");
  endtask

  task automatic rd_reg(int n, logic [31:0] exp, string tag);
    access(1'b1, 4'd0, 32'(n), 32'h0, "idx");
    access(1'b0, 4'd1, 32'h0, exp, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1: unexpected response actual 0x%08h expected none", rsp_rdata);
      end else begin
        item_t it;
        it = q.pop_front();
        if (it.is_rd) chk(it.tag, rsp_rdata, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rmin = 32'd16; rmax = 32'h10000; rnext = 32'd16; rstop = 32'd16; p_idle = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R7 reset enable", 32'(fb_en), 32'd0);
    chk("R8 reset ring_ok", 32'(ring_ok), 32'd0);
    chk("R9 reset busy", 32'(busy), 32'd0);
    chk("R3 reset width", 32'(w_o), 32'd1024);
    chk("R3 reset height", 32'(h_o), 32'd768);

    // R2 version
    rd_reg(0, 32'h9000_0002, "R2 version reset");
    wr_reg(0, 32'h9000_0001);
    rd_reg(0, 32'h9000_0001, "R2 legal write");
    wr_reg(0, 32'h1234_5678);
    rd_reg(0, 32'h9000_0001, "R2 illegal ignored");

    // R1 address map
    access(1'b0, 4'd0, 32'h0, 32'd0, "R1 index readback");
    access(1'b0, 4'd2, 32'h0, 32'd0, "R1 stub read");
    access(1'b1, 4'd2, 32'hDEAD_BEEF, 32'h0, "stub wr");
    access(1'b0, 4'd2, 32'h0, 32'd0, "R1 stub after write");
    access(1'b0, 4'd0, 32'h0, 32'd0, "R1 index untouched by stub");
    access(1'b0, 4'd5, 32'h0, 32'hFFFF_FFFF, "R1 unmapped offset");

    // R3 mode limits
    rd_reg(4, 32'd2360, "R3 max width");
    rd_reg(5, 32'd1770, "R3 max height");
    wr_reg(2, 32'd2361);
    rd_reg(2, 32'd1024, "R3 width over limit");
    wr_reg(2, 32'd2360);
    chk("R3 width port", 32'(w_o), 32'd2360);
    wr_reg(3, 32'd1771);
    chk("R3 height rejected", 32'(h_o), 32'd768);
    wr_reg(3, 32'd1770);
    rd_reg(3, 32'd1770, "R3 height at limit");

    // R5 pitch
    rd_reg(12, 32'd4720, "R5 pitch 2360");
    wr_reg(2, 32'd800);
    rd_reg(12, 32'd1600, "R5 pitch 800");

    // R4 depth
    rd_reg(7, 32'd16, "R4 bpp");
    wr_reg(7, 32'd32);
    rd_reg(7, 32'd16, "R4 bpp write ignored");

    // R6 caps
    rd_reg(17, 32'h0000_00E3, "R6 caps");

    // R7 enable
    wr_reg(1, 32'd1);
    chk("R7 enable port", 32'(fb_en), 32'd1);
    rd_reg(1, 32'd1, "R7 enable read");

    // R8 commit
    wr_reg(20, 32'd1);
    chk("R8 commit ok", 32'(ring_ok), 32'd1);
    rd_reg(20, 32'd1, "R8 commit read");
    wr_reg(20, 32'd0);
    chk("R8 commit zero clears", 32'(ring_ok), 32'd0);
    rnext = 32'd18;
    wr_reg(20, 32'd1);
    chk("R8 misaligned", 32'(ring_ok), 32'd0);
    rnext = 32'd16; rmax = 32'h10004;
    wr_reg(20, 32'd1);
    chk("R8 max over limit", 32'(ring_ok), 32'd0);
    rmax = 32'd10252;
    wr_reg(20, 32'd1);
    chk("R8 span short", 32'(ring_ok), 32'd0);
    rmax = 32'd10256;
    wr_reg(20, 32'd1);
    chk("R8 span exact", 32'(ring_ok), 32'd1);

    // R9 sync / busy
    wr_reg(21, 32'd1);
    chk("R9 start pulse", 32'(p_start), 32'd1);
    @(negedge clk);
    chk("R9 start single", 32'(p_start), 32'd0);
    rd_reg(22, 32'd1, "R9 busy set");
    p_idle = 1'b1;
    @(negedge clk);
    chk("R9 busy port cleared", 32'(busy), 32'd0);
    rd_reg(22, 32'd0, "R9 busy read cleared");

    // R10 cursor
    wr_reg(25, 32'd100);
    wr_reg(26, 32'd55);
    chk("R10 cursor x", cx, 32'd100);
    chk("R10 cursor y", cy, 32'd55);
    wr_reg(24, 32'd7);
    rd_reg(24, 32'd7, "R10 cursor id");
    wr_reg(27, 32'd1);
    chk("R10 on set", 32'(cur_on), 32'd1);
    wr_reg(27, 32'd2);
    chk("R10 value 2 keeps", 32'(cur_on), 32'd1);
    wr_reg(27, 32'd0);
    chk("R10 on clear", 32'(cur_on), 32'd0);
    wr_reg(27, 32'd3);
    rd_reg(27, 32'd0, "R10 value 3 keeps");

    // R11 scratch
    wr_reg(1792, 32'hAAAA_0001);
    wr_reg(1799, 32'hBBBB_0002);
    rd_reg(1792, 32'hAAAA_0001, "R11 scratch first");
    rd_reg(1799, 32'hBBBB_0002, "R11 scratch last");
    rd_reg(1793, 32'd0, "R11 scratch reset");
    wr_reg(1800, 32'hCCCC_0003);
    rd_reg(1800, 32'd0, "R11 above window");
    rd_reg(1791, 32'd0, "R11 below window");

    // R12 unknown
    wr_reg(40, 32'h5555_5555);
    rd_reg(40, 32'd0, "R12 unknown index");
    rd_reg(6, 32'd0, "R12 gap index");

    repeat (3) @(negedge clk);
    chk("R1 all responses seen", 32'(q.size()), 32'd0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule